// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block decides, once per clock, whether the processor core must take an exception or complete an exception return, and produces the full set of state updates for that event at once. Seven exception request lines arrive as one vector, together with the current status word and the address of the instruction in flight. The block masks the two interrupt lines with the interrupt-disable bits of the current status word and selects the highest-priority enabled request. For that request it produces the target mode, the link value for that mode, the copy of the old status word for that mode's saved status register, the new current status word and the vector address for the PC. The register file and PC logic apply all of these in the same cycle.

When no enabled exception is pending and a return is requested, the block instead produces the restored status word, taken from the saved copy, and the return target for the PC. These are issued as one atomic update. An enabled exception always wins over a return in the same cycle.

The outputs are registered, so there is one cycle of latency from the inputs. Each output update lasts exactly one cycle and is marked by `upd_valid`. The consumer cannot stall the block: there is no ready signal, and the register file must accept every update in the cycle it appears. Request inputs are level-sensitive and are evaluated again on every cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bit positions in `exc_req` are 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 undefined instruction, 6 software interrupt. When several enabled requests are present, the lowest bit position wins.
- R2: Bit 3 is ignored while `cur_psr[7]` (I) is 1, and bit 2 is ignored while `cur_psr[6]` (F) is 1. All other requests cannot be masked.
- R3: The target mode is placed in `upd_mode` and in `cpsr_val[4:0]`. Reset and software interrupt use 10011. Both aborts use 10111. Undefined instruction uses 11011. Normal interrupt uses 10010. Fast interrupt uses 10001.
- R4: On entry, `pc_val` is `VEC_BASE` plus an offset chosen by the exception: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R5: On entry, `lr_we` is 1 and `lr_val` is `cur_pc` plus an offset. The offset is 8 for data abort, 0 for reset and 4 for all others; for a software interrupt this is the address of the following instruction.
- R6: On entry, `spsr_we` is 1 and `spsr_val` equals the sampled `cur_psr`.
- R7: On entry, `cpsr_val` equals `cur_psr` with the mode field replaced, bit 5 (T) cleared and bit 7 (I) set. Bit 6 (F) is set for fast interrupt and reset and is kept unchanged otherwise. All other bits are kept.
- R8: A reset request is taken whatever the other requests and mask bits are.
- R9: With `ret_req` high and no enabled exception, the block makes a return update. `upd_is_return` is 1, `cpsr_val` equals `saved_psr`, `upd_mode` equals `saved_psr[4:0]`, `pc_val` equals `ret_target`, and `lr_we` and `spsr_we` are 0.
- R10: `upd_cause` holds the winning request's bit position on entry.
- R11: The outputs reflect the inputs sampled at the previous rising edge. `upd_valid` is 0 when nothing enabled was pending, and all outputs are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 7 | Pending exception requests, one bit per exception |
| cur_psr | input | PW | Current status word |
| cur_pc | input | AW | Address of the current instruction |
| ret_req | input | 1 | Exception return request |
| saved_psr | input | PW | Saved status word of the current mode |
| ret_target | input | AW | PC value to resume at on return |
| upd_valid | output | 1 | An update is issued this cycle |
| upd_is_return | output | 1 | The update is a return, not an entry |
| upd_cause | output | 3 | Winning request position |
| upd_mode | output | 5 | New mode field |
| lr_we | output | 1 | Write the link register of the new mode |
| lr_val | output | AW | Link value |
| spsr_we | output | 1 | Write the saved status register of the new mode |
| spsr_val | output | PW | Status word to save |
| cpsr_val | output | PW | New current status word |
| pc_val | output | AW | New PC value |

## Verification
Directed stimulus first applies request vectors with every bit from some position upward set. This shows that each position beats all positions above it and yields its own mode, vector and link offset. Held interrupt requests are then applied with each mask bit on and off, alone and together with a lower-priority request and a return request. This separates a masked interrupt from an enabled one and shows that a return gives way to an enabled exception. Random request vectors, status words and addresses then exercise the bit-preservation rules of the new status word, with the F bit and the old T bit taking both values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NUM_EXC = 7;
  localparam int CW      = $clog2(NUM_EXC);

  typedef enum logic [CW-1:0] {
    EXC_RESET = 3'd0,
    EXC_DABT  = 3'd1,
    EXC_FIQ   = 3'd2,
    EXC_IRQ   = 3'd3,
    EXC_PABT  = 3'd4,
    EXC_UNDEF = 3'd5,
    EXC_SWI   = 3'd6
  } exc_cause_e;

  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;

  function automatic logic [4:0] cause_mode(exc_cause_e c);
    case (c)
      EXC_DABT, EXC_PABT: return MODE_ABT;
      EXC_FIQ:            return MODE_FIQ;
      EXC_IRQ:            return MODE_IRQ;
      EXC_UNDEF:          return MODE_UND;
      default:            return MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] cause_vec_off(exc_cause_e c);
    case (c)
      EXC_UNDEF: return 8'h04;
      EXC_SWI:   return 8'h08;
      EXC_PABT:  return 8'h0C;
      EXC_DABT:  return 8'h10;
      EXC_IRQ:   return 8'h18;
      EXC_FIQ:   return 8'h1C;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] cause_lr_off(exc_cause_e c);
    case (c)
      EXC_RESET: return 4'd0;
      EXC_DABT:  return 4'd8;
      default:   return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int N  = NUM_EXC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic          mask_irq,
  input  logic          mask_fiq,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] enabled;

  always_comb begin
    enabled = req;
    if (mask_irq) enabled[EXC_IRQ] = 1'b0;
    if (mask_fiq) enabled[EXC_FIQ] = 1'b0;
  end

  always_comb begin
    any = |enabled;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (enabled[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  exc_cause_e    cause,
  input  logic [PW-1:0] cur_psr,
  input  logic [AW-1:0] cur_pc,
  output logic [4:0]    mode,
  output logic [AW-1:0] lr_val,
  output logic [PW-1:0] cpsr_val,
  output logic [AW-1:0] pc_val
);
  always_comb begin
    mode          = cause_mode(cause);
    lr_val        = cur_pc + AW'(cause_lr_off(cause));
    pc_val        = VEC_BASE + AW'(cause_vec_off(cause));
    cpsr_val      = cur_psr;
    cpsr_val[4:0] = mode;
    cpsr_val[BIT_T] = 1'b0;
    cpsr_val[BIT_I] = 1'b1;
    if (cause == EXC_FIQ || cause == EXC_RESET) cpsr_val[BIT_F] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EXC-1:0]   exc_req,
  input  logic [PW-1:0]        cur_psr,
  input  logic [AW-1:0]        cur_pc,
  input  logic                 ret_req,
  input  logic [PW-1:0]        saved_psr,
  input  logic [AW-1:0]        ret_target,
  output logic                 upd_valid,
  output logic                 upd_is_return,
  output logic [CW-1:0]        upd_cause,
  output logic [4:0]           upd_mode,
  output logic                 lr_we,
  output logic [AW-1:0]        lr_val,
  output logic                 spsr_we,
  output logic [PW-1:0]        spsr_val,
  output logic [PW-1:0]        cpsr_val,
  output logic [AW-1:0]        pc_val
);
  logic          take;
  logic [CW-1:0] win_idx;
  exc_cause_e    win;
  logic [4:0]    f_mode;
  logic [AW-1:0] f_lr;
  logic [PW-1:0] f_cpsr;
  logic [AW-1:0] f_pc;

  exc_arbiter #(.N(NUM_EXC)) u_arb (
    .req      (exc_req),
    .mask_irq (cur_psr[BIT_I]),
    .mask_fiq (cur_psr[BIT_F]),
    .any      (take),
    .idx      (win_idx)
  );

  assign win = exc_cause_e'(win_idx);

  exc_frame_gen #(.AW(AW), .PW(PW), .VEC_BASE(VEC_BASE)) u_frame (
    .cause    (win),
    .cur_psr  (cur_psr),
    .cur_pc   (cur_pc),
    .mode     (f_mode),
    .lr_val   (f_lr),
    .cpsr_val (f_cpsr),
    .pc_val   (f_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid     <= 1'b0;
      upd_is_return <= 1'b0;
      upd_cause     <= '0;
      upd_mode      <= '0;
      lr_we         <= 1'b0;
      lr_val        <= '0;
      spsr_we       <= 1'b0;
      spsr_val      <= '0;
      cpsr_val      <= '0;
      pc_val        <= '0;
    end else begin
      upd_valid     <= take | ret_req;
      upd_is_return <= ~take & ret_req;
      upd_cause     <= take ? win_idx : '0;
      upd_mode      <= take ? f_mode : saved_psr[4:0];
      lr_we         <= take;
      lr_val        <= take ? f_lr : '0;
      spsr_we       <= take;
      spsr_val      <= take ? cur_psr : '0;
      cpsr_val      <= take ? f_cpsr : saved_psr;
      pc_val        <= take ? f_pc : ret_target;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EXC-1:0] exc_req,
  input logic [PW-1:0]      cur_psr,
  input logic [AW-1:0]      cur_pc,
  input logic               ret_req,
  input logic [PW-1:0]      saved_psr,
  input logic [AW-1:0]      ret_target,
  input logic               upd_valid,
  input logic               upd_is_return,
  input logic [CW-1:0]      upd_cause,
  input logic [4:0]         upd_mode,
  input logic               lr_we,
  input logic [AW-1:0]      lr_val,
  input logic               spsr_we,
  input logic [PW-1:0]      spsr_val,
  input logic [PW-1:0]      cpsr_val,
  input logic [AW-1:0]      pc_val
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req[EXC_IRQ] && cur_psr[BIT_I]) |=> !(lr_we && upd_cause == EXC_IRQ)); // R2

  AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req[EXC_FIQ] && cur_psr[BIT_F]) |=> !(lr_we && upd_cause == EXC_FIQ)); // R2

  AST_SPSR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_is_return) |-> (spsr_we && spsr_val == $past(cur_psr))); // R6

  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_is_return) |-> (!cpsr_val[BIT_T] && cpsr_val[BIT_I])); // R7

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req[EXC_RESET] |=> (lr_we && upd_cause == EXC_RESET && upd_mode == MODE_SVC)); // R8

  AST_RETURN_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_is_return) |-> (!lr_we && !spsr_we
      && cpsr_val == $past(saved_psr) && pc_val == $past(ret_target))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> (!lr_we && !spsr_we)); // R11
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .PW(PW)) u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int AW = 32;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    exc_req = '0;
  logic [PW-1:0] cur_psr = '0;
  logic [AW-1:0] cur_pc = '0;
  logic          ret_req = 1'b0;
  logic [PW-1:0] saved_psr = '0;
  logic [AW-1:0] ret_target = '0;
  logic          upd_valid, upd_is_return, lr_we, spsr_we;
  logic [2:0]    upd_cause;
  logic [4:0]    upd_mode;
  logic [AW-1:0] lr_val, pc_val;
  logic [PW-1:0] spsr_val, cpsr_val;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl uut (.*);

  function automatic logic [4:0] m_mode(int c);
    case (c)
      1, 4: return 5'b10111;
      2: return 5'b10001;
      3: return 5'b10010;
      5: return 5'b11011;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [AW-1:0] m_vec(int c);
    case (c)
      1: return 32'h10;
      2: return 32'h1C;
      3: return 32'h18;
      4: return 32'h0C;
      5: return 32'h04;
      6: return 32'h08;
      default: return 32'h00;
    endcase
  endfunction

  function automatic int m_winner(logic [6:0] r, logic [PW-1:0] p);
    logic [6:0] en = r;
    if (p[7]) en[3] = 1'b0;
    if (p[6]) en[2] = 1'b0;
    for (int k = 0; k < 7; k++) if (en[k]) return k;
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [6:0] r, logic [PW-1:0] p, logic [AW-1:0] pc,
                      logic rq, logic [PW-1:0] sp, logic [AW-1:0] rt);
    int w;
    logic [PW-1:0] ep;
    exc_req = r; cur_psr = p; cur_pc = pc; ret_req = rq; saved_psr = sp; ret_target = rt;
    w = m_winner(r, p);
    @(negedge clk);
    if (w >= 0) begin
      ep = p;
      ep[4:0] = m_mode(w);
      ep[5] = 1'b0;
      ep[7] = 1'b1;
      if (w == 0 || w == 2) ep[6] = 1'b1;
      chk("R11", "valid", 64'(upd_valid), 64'd1);
      chk("R9", "is_return", 64'(upd_is_return), 64'd0);
      chk("R10", "cause", 64'(upd_cause), 64'(w));
      chk("R1", "cause_order", 64'(upd_cause), 64'(w));
      chk("R3", "mode", 64'(upd_mode), 64'(m_mode(w)));
      chk("R4", "pc", 64'(pc_val), 64'(m_vec(w)));
      chk("R5", "lr_we", 64'(lr_we), 64'd1);
      chk("R5", "lr", 64'(lr_val), 64'(pc + ((w == 1) ? 32'd8 : (w == 0) ? 32'd0 : 32'd4)));
      chk("R6", "spsr", 64'({spsr_we, spsr_val}), 64'({1'b1, p}));
      chk("R7", "cpsr", 64'(cpsr_val), 64'(ep));
    end else if (rq) begin
      chk("R9", "ret", 64'({upd_valid, upd_is_return, lr_we, spsr_we}), 64'(4'b1100));
      chk("R9", "ret_psr", 64'(cpsr_val), 64'(sp));
      chk("R9", "ret_mode", 64'(upd_mode), 64'(sp[4:0]));
      chk("R9", "ret_pc", 64'(pc_val), 64'(rt));
    end else begin
      chk("R2", "idle", 64'({upd_valid, lr_we, spsr_we}), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    chk("R11", "reset_outputs", 64'({upd_valid, lr_we, spsr_we, cpsr_val[7:0]}), 64'd0);
    rst_n = 1'b1;
    // R1 R8: each position beats all higher ones
    for (int k = 0; k < 7; k++)
      step(7'h7F & ~7'((1 << k) - 1), 32'h0000_0020, 32'h8000 + 32'(k * 16), 1'b0, 32'h0, 32'h0);
    // R8: reset ignores masks
    step(7'h01, 32'hFFFF_FFFF, 32'h100, 1'b1, 32'h1234_5610, 32'h4000);
    // R2: masked interrupts, held level
    step(7'h08, 32'h0000_0080, 32'h200, 1'b0, 32'h0, 32'h0);
    step(7'h08, 32'h0000_0080, 32'h200, 1'b1, 32'hA000_0010, 32'h5004);
    step(7'h04, 32'h0000_0040, 32'h204, 1'b0, 32'h0, 32'h0);
    step(7'h0C, 32'h0000_0040, 32'h208, 1'b0, 32'h0, 32'h0);
    step(7'h0C, 32'h0000_0080, 32'h20C, 1'b0, 32'h0, 32'h0);
    step(7'h1C, 32'h0000_00C0, 32'h210, 1'b1, 32'h0, 32'h6000);
    step(7'h08, 32'h0000_0000, 32'h214, 1'b1, 32'h1F, 32'h7000);
    // R9: plain return
    step(7'h00, 32'h0000_0013, 32'h300, 1'b1, 32'h6000_0030, 32'h0000_8002);
    step(7'h00, 32'h0000_0013, 32'h300, 1'b0, 32'h0, 32'h0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [6:0] r = 7'($urandom) & 7'($urandom);
      if (($urandom % 16) != 0) r[0] = 1'b0;
      step(r, $urandom, $urandom, 1'($urandom), $urandom, $urandom);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule